// File: doc/BRIEF.md
# Complementary Output Compare Channel

This block is one compare channel of a general-purpose timer. Each clock it compares the timer's running count with a programmed compare value. A three-bit mode field says how the greater, equal and less-than relations move an active-high reference signal, which is held in a register. A match event also latches a sticky compare flag. Software clears the flag with a one-cycle clear strobe.

The reference drives a pair of outputs: a main output and a complementary output. A dead-time state machine sits between the reference and the two outputs. It holds back the turn-on of each output by a programmable number of clocks, so the two raw outputs are never active together. Each output then passes through its own polarity and enable stage.

The parameter `HAS_COMP` selects the variant. When it is 0, the channel has a single main output that follows the reference with the same one-clock latency, and the complementary pin is tied low.

Dead-time state machine (only when `HAS_COMP`=1):

| State | Raw outputs |
|---|---|
| `DT_COMP_ON` (reset state) | complementary raw active |
| `DT_WAIT_MAIN` | both raw outputs inactive, counting down before main turns on |
| `DT_MAIN_ON` | main raw active |
| `DT_WAIT_COMP` | both raw outputs inactive, counting down before complementary turns on |

Transitions:

- **COMP_ON to MAIN_ON or WAIT_MAIN.** When the reference is seen high, the machine goes straight to MAIN_ON if the dead count is 0. Otherwise it goes to WAIT_MAIN and loads the counter with the dead count minus one.
- **MAIN_ON to COMP_ON or WAIT_COMP.** The same rule applies when the reference is seen low.
- **WAIT_MAIN.**
  - It moves to MAIN_ON when the counter reaches 0.
  - If the reference drops first, it aborts. The target is COMP_ON when the dead count is 0, otherwise WAIT_COMP with the counter reloaded.
- **WAIT_COMP.** It behaves the same way with the roles of the two outputs swapped.

Top module: `occ_channel`

## Requirements
- R1: In mode 3'b110 the reference after a clock edge equals (count < compare) sampled at that edge.
- R2: In mode 3'b111 the reference after a clock edge equals (count >= compare) sampled at that edge.
- R3: On an equal match at an edge, the reference behaves by mode:
  - mode 3'b001 sets it;
  - mode 3'b010 clears it;
  - mode 3'b011 inverts it.

  In mode 3'b000 the reference keeps its value. With no match, modes 3'b001 to 3'b011 also keep it.
- R4: Mode 3'b100 drives the reference low and mode 3'b101 drives it high from the next edge.
- R5: An equal match at an edge sets the compare flag. Otherwise a clear strobe high at an edge clears it. A match wins over a simultaneous clear.
- R6: With a dead count of 0, the raw main output is the reference delayed by one clock, and the raw complementary output is its exact inverse.
- R7: With a dead count D>0, a raw output turns on only once the reference has held that output's level at D+1 consecutive edges. The two raw outputs are never active at the same time.
- R8: A polarity bit of 1 inverts its enabled output. A polarity bit of 0 passes the raw level through.
- R9: A disabled output drives its inactive level, which equals its polarity bit.
- R10: With `HAS_COMP`=0, the main output follows the reference delayed by one clock, and the complementary output stays 0.
- R11: During reset the following hold:
  - the reference and the flag are 0;
  - the raw main output is inactive;
  - the raw complementary output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | CNT_W | Timer counter value |
| compare_i | input | CNT_W | Compare value |
| mode_i | input | 3 | Compare-mode field |
| dead_i | input | DT_W | Dead-time count in clocks |
| pol_main_i | input | 1 | Main output polarity (1 inverts) |
| pol_comp_i | input | 1 | Complementary output polarity (1 inverts) |
| en_main_i | input | 1 | Main output enable |
| en_comp_i | input | 1 | Complementary output enable |
| flag_clr_i | input | 1 | Compare flag clear strobe |
| ref_o | output | 1 | Active-high reference |
| flag_o | output | 1 | Compare flag |
| out_main_o | output | 1 | Main output pin level |
| out_comp_o | output | 1 | Complementary output pin level |

## Verification
The bench builds two copies with a 4-bit counter and a 3-bit dead count: one with `HAS_COMP`=1 and one with `HAS_COMP`=0. Both copies share every input. The narrow counter lets each compare value see every count value, including the cases where the compare value is 0 or 15. With dead counts of 0, 1, 2 and 5, the bench sweeps all eight modes. The mix of long and short reference pulses exercises both completed dead bands and aborted ones. Polarity and enable bits cycle through all sixteen combinations within every sweep.

// File: rtl/occ_pkg.sv
package occ_pkg;

    typedef enum logic [2:0] {
        CM_FROZEN    = 3'b000,
        CM_SET       = 3'b001,
        CM_CLEAR     = 3'b010,
        CM_TOGGLE    = 3'b011,
        CM_FORCE_LO  = 3'b100,
        CM_FORCE_HI  = 3'b101,
        CM_PWM_LOW_W = 3'b110,
        CM_PWM_HI_W  = 3'b111
    } cmp_mode_e;

    typedef enum logic [1:0] {
        DT_COMP_ON   = 2'd0,
        DT_WAIT_MAIN = 2'd1,
        DT_MAIN_ON   = 2'd2,
        DT_WAIT_COMP = 2'd3
    } dt_state_e;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rel_t;

endpackage

// File: rtl/occ_compare.sv
module occ_compare #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] compare_i,
    output occ_pkg::rel_t    rel_o
);
    always_comb begin
        rel_o.gt = (count_i > compare_i);
        rel_o.eq = (count_i == compare_i);
        rel_o.lt = (count_i < compare_i);
    end
endmodule

// File: rtl/occ_refgen.sv
module occ_refgen
    import occ_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  rel_t       rel_i,
    input  logic       flag_clr_i,
    output logic       ref_o,
    output logic       flag_o
);
    cmp_mode_e mode;
    logic      ref_d;
    logic      flag_d;

    assign mode = cmp_mode_e'(mode_i);

    always_comb begin
        ref_d = ref_o;
        unique case (mode)
            CM_FROZEN:    ref_d = ref_o;
            CM_SET:       ref_d = rel_i.eq ? 1'b1 : ref_o;
            CM_CLEAR:     ref_d = rel_i.eq ? 1'b0 : ref_o;
            CM_TOGGLE:    ref_d = rel_i.eq ? ~ref_o : ref_o;
            CM_FORCE_LO:  ref_d = 1'b0;
            CM_FORCE_HI:  ref_d = 1'b1;
            CM_PWM_LOW_W: ref_d = rel_i.lt;
            CM_PWM_HI_W:  ref_d = rel_i.gt | rel_i.eq;
        endcase
    end

    always_comb begin
        if (rel_i.eq)        flag_d = 1'b1;
        else if (flag_clr_i) flag_d = 1'b0;
        else                 flag_d = flag_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_o  <= 1'b0;
            flag_o <= 1'b0;
        end else begin
            ref_o  <= ref_d;
            flag_o <= flag_d;
        end
    end
endmodule

// File: rtl/occ_deadtime.sv
module occ_deadtime
    import occ_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            main_raw_o,
    output logic            comp_raw_o
);
    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    dt_state_e       state_q, state_d;
    logic [DT_W-1:0] left_q, left_d;
    logic            dead_zero;
    logic            left_zero;

    assign dead_zero = (dead_i == '0);
    assign left_zero = (left_q == '0);

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            DT_COMP_ON: begin
                if (ref_i) begin
                    if (dead_zero) state_d = DT_MAIN_ON;
                    else begin
                        state_d = DT_WAIT_MAIN;
                        left_d  = dead_i - ONE;
                    end
                end
            end
            DT_WAIT_MAIN: begin
                if (!ref_i) begin
                    if (dead_zero) state_d = DT_COMP_ON;
                    else begin
                        state_d = DT_WAIT_COMP;
                        left_d  = dead_i - ONE;
                    end
                end else if (left_zero) begin
                    state_d = DT_MAIN_ON;
                end else begin
                    left_d = left_q - ONE;
                end
            end
            DT_MAIN_ON: begin
                if (!ref_i) begin
                    if (dead_zero) state_d = DT_COMP_ON;
                    else begin
                        state_d = DT_WAIT_COMP;
                        left_d  = dead_i - ONE;
                    end
                end
            end
            DT_WAIT_COMP: begin
                if (ref_i) begin
                    if (dead_zero) state_d = DT_MAIN_ON;
                    else begin
                        state_d = DT_WAIT_MAIN;
                        left_d  = dead_i - ONE;
                    end
                end else if (left_zero) begin
                    state_d = DT_COMP_ON;
                end else begin
                    left_d = left_q - ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DT_COMP_ON;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        main_raw_o = 1'b0;
        comp_raw_o = 1'b0;
        unique case (state_q)
            DT_COMP_ON:   comp_raw_o = 1'b1;
            DT_MAIN_ON:   main_raw_o = 1'b1;
            DT_WAIT_MAIN,
            DT_WAIT_COMP: begin
                main_raw_o = 1'b0;
                comp_raw_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/occ_outstage.sv
module occ_outstage (
    input  logic raw_i,
    input  logic pol_i,
    input  logic en_i,
    output logic pin_o
);
    always_comb begin
        if (en_i) pin_o = raw_i ^ pol_i;
        else      pin_o = pol_i;
    end
endmodule

// File: rtl/occ_channel.sv
module occ_channel
    import occ_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DT_W     = 8,
    parameter bit HAS_COMP = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] compare_i,
    input  logic [2:0]       mode_i,
    input  logic [DT_W-1:0]  dead_i,
    input  logic             pol_main_i,
    input  logic             pol_comp_i,
    input  logic             en_main_i,
    input  logic             en_comp_i,
    input  logic             flag_clr_i,
    output logic             ref_o,
    output logic             flag_o,
    output logic             out_main_o,
    output logic             out_comp_o
);
    rel_t rel;
    logic main_raw;
    logic comp_raw;

    occ_compare #(.CNT_W(CNT_W)) u_compare (
        .count_i   (count_i),
        .compare_i (compare_i),
        .rel_o     (rel)
    );

    occ_refgen u_refgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .rel_i      (rel),
        .flag_clr_i (flag_clr_i),
        .ref_o      (ref_o),
        .flag_o     (flag_o)
    );

    occ_outstage u_out_main (
        .raw_i (main_raw),
        .pol_i (pol_main_i),
        .en_i  (en_main_i),
        .pin_o (out_main_o)
    );

    generate
        if (HAS_COMP) begin : g_pair
            occ_deadtime #(.DT_W(DT_W)) u_dead (
                .clk        (clk),
                .rst_n      (rst_n),
                .ref_i      (ref_o),
                .dead_i     (dead_i),
                .main_raw_o (main_raw),
                .comp_raw_o (comp_raw)
            );

            occ_outstage u_out_comp (
                .raw_i (comp_raw),
                .pol_i (pol_comp_i),
                .en_i  (en_comp_i),
                .pin_o (out_comp_o)
            );
        end else begin : g_single
            logic main_q;
            logic unused_ok;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) main_q <= 1'b0;
                else        main_q <= ref_o;
            end

            assign main_raw   = main_q;
            assign comp_raw   = 1'b0;
            assign out_comp_o = 1'b0;
            assign unused_ok  = ^{dead_i, pol_comp_i, en_comp_i};
        end
    endgenerate
endmodule

// File: rtl/occ_channel_chk.sv
module occ_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_i,
    input logic [CNT_W-1:0] compare_i,
    input logic [2:0]       mode_i,
    input logic             flag_clr_i,
    input logic             ref_o,
    input logic             flag_o,
    input logic             main_raw,
    input logic             comp_raw
);
    // R1
    pwm_low_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b110) |=> (ref_o == $past(count_i < compare_i)));

    // R3
    set_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b001 && count_i == compare_i) |=> ref_o);

    // R4
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b101) |=> ref_o);

    // R4
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b100) |=> !ref_o);

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i == compare_i) |=> flag_o);

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && count_i != compare_i) |=> !flag_o);

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_raw && comp_raw));
endmodule

bind occ_channel occ_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_i    (count_i),
    .compare_i  (compare_i),
    .mode_i     (mode_i),
    .flag_clr_i (flag_clr_i),
    .ref_o      (ref_o),
    .flag_o     (flag_o),
    .main_raw   (main_raw),
    .comp_raw   (comp_raw)
);

// File: tb/test_occ_channel.sv
`timescale 1ns/1ps
module test_occ_channel;
    localparam int CW = 4;
    localparam int DW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cnt = '0;
    logic [CW-1:0] cmp = '0;
    logic [2:0]    mode = 3'b000;
    logic [DW-1:0] dead = '0;
    logic          pol_m = 1'b0, pol_c = 1'b0, en_m = 1'b1, en_c = 1'b1, clr = 1'b0;

    logic ref_a, flag_a, om_a, oc_a;
    logic ref_s, flag_s, om_s, oc_s;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // model state
    logic m_ref, m_flag, m_main, m_comp, s_raw;
    int   run0, run1;

    always #10 clk = ~clk;

    occ_channel #(.CNT_W(CW), .DT_W(DW), .HAS_COMP(1'b1)) i_occ_channel (
        .clk(clk), .rst_n(rst_n), .count_i(cnt), .compare_i(cmp), .mode_i(mode),
        .dead_i(dead), .pol_main_i(pol_m), .pol_comp_i(pol_c), .en_main_i(en_m),
        .en_comp_i(en_c), .flag_clr_i(clr), .ref_o(ref_a), .flag_o(flag_a),
        .out_main_o(om_a), .out_comp_o(oc_a));

    occ_channel #(.CNT_W(CW), .DT_W(DW), .HAS_COMP(1'b0)) i_occ_channel_single (
        .clk(clk), .rst_n(rst_n), .count_i(cnt), .compare_i(cmp), .mode_i(mode),
        .dead_i(dead), .pol_main_i(pol_m), .pol_comp_i(pol_c), .en_main_i(en_m),
        .en_comp_i(en_c), .flag_clr_i(clr), .ref_o(ref_s), .flag_o(flag_s),
        .out_main_o(om_s), .out_comp_o(oc_s));

    task automatic check(input logic act, input logic exp, input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b (mode=%0d cnt=%0d cmp=%0d dead=%0d)",
                     req, what, act, exp, mode, cnt, cmp, dead);
        end
    endtask

    function automatic logic pin(input logic raw, input logic pol, input logic en);
        return en ? (raw ^ pol) : pol;
    endfunction

    function automatic string pin_req(input logic pol, input logic en);
        if (!en)                 return "R9";
        if (pol)                 return "R8";
        if (dead == '0)          return "R6";
        return "R7";
    endfunction

    function automatic string ref_req();
        case (mode)
            3'b110:  return "R1";
            3'b111:  return "R2";
            3'b100, 3'b101: return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic model_reset();
        m_ref = 1'b0; m_flag = 1'b0; m_main = 1'b0; m_comp = 1'b1; s_raw = 1'b0;
        run0 = 1000; run1 = 0;
    endtask

    task automatic model_step();
        logic eq, lt, nr;
        eq = (cnt == cmp);
        lt = (cnt < cmp);
        case (mode)
            3'b000: nr = m_ref;
            3'b001: nr = eq ? 1'b1 : m_ref;
            3'b010: nr = eq ? 1'b0 : m_ref;
            3'b011: nr = eq ? ~m_ref : m_ref;
            3'b100: nr = 1'b0;
            3'b101: nr = 1'b1;
            3'b110: nr = lt;
            default: nr = ~lt;
        endcase
        if (eq)       m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        if (m_ref) begin run1 = (run1 < 1000) ? run1 + 1 : run1; run0 = 0; end
        else       begin run0 = (run0 < 1000) ? run0 + 1 : run0; run1 = 0; end
        m_main = (run1 >= int'(dead) + 1);
        m_comp = (run0 >= int'(dead) + 1);
        s_raw  = m_ref;
        m_ref  = nr;
    endtask

    task automatic check_all();
        check(ref_a, m_ref, ref_req(), "ref");
        check(flag_a, m_flag, "R5", "flag");
        check(om_a, pin(m_main, pol_m, en_m), pin_req(pol_m, en_m), "main pin");
        check(oc_a, pin(m_comp, pol_c, en_c), pin_req(pol_c, en_c), "comp pin");
        if (en_m && en_c && !pol_m && !pol_c)
            check(om_a & oc_a, 1'b0, "R7", "overlap at pins");
        check(ref_s, m_ref, ref_req(), "single ref");
        check(om_s, pin(s_raw, pol_m, en_m), "R10", "single main pin");
        check(oc_s, 1'b0, "R10", "single comp pin");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        check(ref_a, 1'b0, "R11", "reset ref");
        check(flag_a, 1'b0, "R11", "reset flag");
        check(om_a, pin(1'b0, pol_m, en_m), "R11", "reset main pin");
        check(oc_a, pin(1'b1, pol_c, en_c), "R11", "reset comp pin");
        rst_n = 1'b1;
    endtask

    initial begin
        int cyc;
        int cmp_set [4];
        int dt_set  [4];
        cmp_set = '{0, 3, 9, 15};
        dt_set  = '{0, 1, 2, 5};
        cyc = 0;
        model_reset();
        for (int d = 0; d < 4; d++) begin
            dead = DW'(dt_set[d]);
            do_reset();
            for (int m = 0; m < 8; m++) begin
                for (int c = 0; c < 4; c++) begin
                    for (int k = 0; k < 32; k++) begin
                        // inputs change at negedge, after checking state
                        mode = 3'(m);
                        cmp  = CW'(cmp_set[c]);
                        cnt  = (c == 2 && k >= 16) ? CW'(cmp_set[c] + (k % 3) - 1) : CW'(k);
                        {en_c, en_m, pol_c, pol_m} = 4'(~(cyc >> 3));
                        clr  = (cyc % 5 == 0);
                        @(posedge clk);
                        model_step();
                        @(negedge clk);
                        check_all();
                        cyc++;
                    end
                end
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule